// File: doc/BRIEF.md
# Countdown Seconds Alarm with Wakeup

This block is a relative alarm that counts whole seconds. Software writes an interval in seconds into a load register. The block adopts that value at the next pulse of the one-second tick input. After that, each tick lowers the count by one, provided the run-enable bit is set. When the count steps from one to zero, a sticky pending flag is raised and the counter parks at zero. The pending flag drives an interrupt output when the interrupt-enable bit is set. It drives a wakeup output when the wakeup-routing bit is set. Software clears the flag by writing one to it. Writing zero to the load register disarms any countdown.

The sequencing is held in a four-state machine:

- CD_IDLE: nothing armed, and the count reads zero.
- CD_ARMED: a nonzero interval is waiting for the next tick.
- CD_COUNT: the count is running.
- CD_DONE: the count expired and is parked at zero.

The transitions are:

- ARM: any state goes to CD_ARMED on a nonzero load write.
- CANCEL: any state goes to CD_IDLE on a zero load write.
- START: CD_ARMED goes to CD_COUNT on a tick.
- EXPIRE: CD_COUNT goes to CD_DONE on an enabled tick that finds a count of one.

A load write in the same cycle as a tick takes priority, and that tick is not used.

Register map (word addresses on `bus_addr`):

| Address | Access | Contents |
|---|---|---|
| 0 | read/write | Staged interval |
| 1 | read-only | Remaining count |
| 2 | read/write | Bit 0 is the run enable |
| 3 | read/write | Bit 0 is the interrupt enable |
| 4 | read, write one to clear | Bit 0 is the pending flag |
| 5 | read/write | Bit 0 routes pending to the wakeup output |

Other addresses read as zero. Reads are combinational from `bus_addr`. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset, every register reads zero, and irq and wake are low.
- R2: A nonzero write to address 0 leaves the remaining count (address 1) unchanged until the next tick. That tick sets the remaining count to the written value, whether or not the run enable is set. Address 0 reads back the written value.
- R3: While counting, each tick with address 2 bit 0 set lowers the remaining count by one. A tick with that bit clear leaves the count unchanged.
- R4: When the count steps from 1 to 0, address 4 bit 0 becomes 1 at that same edge. The count then stays 0, and further ticks never set the pending bit again.
- R5: Writing 1 to address 4 bit 0 clears the pending bit. Writing 0 to it has no effect. Clearing the run enable leaves the pending bit set.
- R6: irq equals the pending bit AND address 3 bit 0.
- R7: wake equals the pending bit AND address 5 bit 0.
- R8: Writing 0 to address 0 makes the remaining count 0 at the next edge. No later tick sets the pending bit until a new nonzero load.
- R9: If expiry and a write of 1 to address 4 fall on the same edge, the pending bit ends up set.
- R10: A load write on the same edge as a tick wins. The count keeps its old value at that edge, and the new value is adopted at the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sec_tick | input | 1 | One-cycle pulse once per second |
| irq | output | 1 | Interrupt: pending AND interrupt enable |
| wake | output | 1 | Wakeup: pending AND wakeup routing |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the expiry event and a software write of one to the pending bit. The bench provokes this by driving the last enabled tick together with the clearing write on one edge. It judges the result correct only if the pending bit and irq read set afterwards.

The second pair is a load write and a tick. The bench issues both together while a count is running. It expects the remaining count to stay at its old value at that edge. It expects the new interval to appear only at the following tick.

// File: rtl/cda_pkg.sv
package cda_pkg;

    typedef enum logic [1:0] {
        CD_IDLE,
        CD_ARMED,
        CD_COUNT,
        CD_DONE
    } cd_state_e;

    localparam int unsigned REG_LOAD   = 0;
    localparam int unsigned REG_REMAIN = 1;
    localparam int unsigned REG_RUN    = 2;
    localparam int unsigned REG_IRQEN  = 3;
    localparam int unsigned REG_STATUS = 4;
    localparam int unsigned REG_WAKE   = 5;

endpackage

// File: rtl/cda_countdown.sv
module cda_countdown
    import cda_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             run_en,
    output logic [CNT_W-1:0] remain,
    output logic [CNT_W-1:0] staged,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cd_state_e        state_q, state_d;
    logic [CNT_W-1:0] remain_q, remain_d;
    logic [CNT_W-1:0] staged_q, staged_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CD_IDLE;
            remain_q <= '0;
            staged_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            staged_q <= staged_d;
        end
    end

    // Transitions: a load write (ARM or CANCEL) outranks a tick
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        staged_d = staged_q;
        expire   = 1'b0;
        if (load_wr) begin
            staged_d = load_val;
            if (load_val == '0) begin
                state_d  = CD_IDLE;
                remain_d = '0;
            end else begin
                state_d = CD_ARMED;
            end
        end else begin
            unique case (state_q)
                CD_IDLE, CD_DONE: begin
                end
                CD_ARMED: begin
                    if (tick) begin
                        state_d  = CD_COUNT;
                        remain_d = staged_q;
                    end
                end
                CD_COUNT: begin
                    if (tick && run_en) begin
                        if (remain_q == ONE) begin
                            remain_d = '0;
                            state_d  = CD_DONE;
                            expire   = 1'b1;
                        end else begin
                            remain_d = remain_q - ONE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        remain = remain_q;
        staged = staged_q;
    end

    // R8: a zero load empties the count at the next edge
    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_wr && load_val == '0) |=> (remain_q == '0 && state_q == CD_IDLE));

    // R3: a disabled tick leaves the count unchanged
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CD_COUNT && !run_en && !load_wr) |=> $stable(remain_q));

    // R3: an enabled tick lowers the count by one
    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CD_COUNT && tick && run_en && !load_wr && remain_q > ONE)
        |=> remain_q == $past(remain_q) - ONE);

    // R4: once expired, the count stays at zero
    p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CD_DONE && !load_wr) |=> (remain_q == '0 && !expire));

endmodule

// File: rtl/cda_regs.sv
module cda_regs
    import cda_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  remain,
    input  logic [CNT_W-1:0]  staged,
    input  logic              expire,
    output logic [DATA_W-1:0] rdata,
    output logic              load_wr,
    output logic              run_en,
    output logic              irq,
    output logic              wake
);

    logic run_q, ie_q, wk_q, pend_q;
    logic clr_hit;

    assign load_wr = bus_wr && (bus_addr == ADDR_W'(REG_LOAD));
    assign clr_hit = bus_wr && (bus_addr == ADDR_W'(REG_STATUS)) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ie_q   <= 1'b0;
            wk_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_W'(REG_RUN))   run_q <= bus_wdata[0];
            if (bus_wr && bus_addr == ADDR_W'(REG_IRQEN)) ie_q  <= bus_wdata[0];
            if (bus_wr && bus_addr == ADDR_W'(REG_WAKE))  wk_q  <= bus_wdata[0];
            // Expiry outranks a clearing write on the same edge
            if (expire)       pend_q <= 1'b1;
            else if (clr_hit) pend_q <= 1'b0;
        end
    end

    always_comb begin
        run_en = run_q;
        irq    = pend_q & ie_q;
        wake   = pend_q & wk_q;
        rdata  = '0;
        case (bus_addr)
            ADDR_W'(REG_LOAD):   rdata = DATA_W'(staged);
            ADDR_W'(REG_REMAIN): rdata = DATA_W'(remain);
            ADDR_W'(REG_RUN):    rdata = DATA_W'(run_q);
            ADDR_W'(REG_IRQEN):  rdata = DATA_W'(ie_q);
            ADDR_W'(REG_STATUS): rdata = DATA_W'(pend_q);
            ADDR_W'(REG_WAKE):   rdata = DATA_W'(wk_q);
            default:             rdata = '0;
        endcase
    end

    // R5: pending holds until a clearing write
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_hit) |=> pend_q);

    // R9: an expiry always leaves the flag set
    p_setwins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q);

endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sec_tick,
    output logic              irq,
    output logic              wake
);

    logic             load_wr;
    logic             run_en;
    logic             expire;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] staged;

    cda_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .remain    (remain),
        .staged    (staged),
        .expire    (expire),
        .rdata     (bus_rdata),
        .load_wr   (load_wr),
        .run_en    (run_en),
        .irq       (irq),
        .wake      (wake)
    );

    cda_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_wr  (load_wr),
        .load_val (bus_wdata[CNT_W-1:0]),
        .tick     (sec_tick),
        .run_en   (run_en),
        .remain   (remain),
        .staged   (staged),
        .expire   (expire)
    );

endmodule

// File: tb/sec_countdown_alarm_test.sv
module sec_countdown_alarm_test;

    localparam logic [2:0] A_LOAD = 3'd0, A_REM = 3'd1, A_RUN = 3'd2,
                           A_IE = 3'd3, A_STAT = 3'd4, A_WAKE = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_tick = 1'b0;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        logic        ei;
        logic        ew;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    sec_countdown_alarm uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sec_tick  (sec_tick),
        .irq       (irq),
        .wake      (wake)
    );

    // Monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (bus_rdata !== e.data || irq !== e.ei || wake !== e.ew) begin
                    errors++;
                    $display("FAIL %s rdata=%h exp=%h irq=%b exp=%b wake=%b exp=%b",
                             e.tag, bus_rdata, e.data, irq, e.ei, wake, e.ew);
                end
            end
        end
    end

    task automatic chk(input logic [2:0] a, input logic [31:0] d,
                       input logic ei, input logic ew, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        sec_tick = 1'b0;
        sb.push_back('{d, ei, ew, tag});
    endtask

    task automatic drive(input logic w, input logic [2:0] a,
                         input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = w;
        sec_tick  = t;
        @(posedge clk);
        #1;
        bus_wr   = 1'b0;
        sec_tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0);
    endtask

    task automatic tk();
        drive(1'b0, A_REM, 32'd0, 1'b1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(A_REM, 0, 0, 0, "R1 remain");
        chk(A_STAT, 0, 0, 0, "R1 status");
        chk(A_RUN, 0, 0, 0, "R1 run");
        chk(A_LOAD, 0, 0, 0, "R1 load");

        // R2: load adopted at the next tick, enable off
        wr(A_LOAD, 3);
        chk(A_REM, 0, 0, 0, "R2 before tick");
        chk(A_LOAD, 3, 0, 0, "R2 readback");
        tk();
        chk(A_REM, 3, 0, 0, "R2 adopted");

        // R3: no count while disabled, then count down
        tk();
        chk(A_REM, 3, 0, 0, "R3 hold disabled");
        wr(A_RUN, 1);
        tk();
        chk(A_REM, 2, 0, 0, "R3 decrement");
        wr(A_IE, 1);
        wr(A_WAKE, 1);
        tk();
        chk(A_REM, 1, 0, 0, "R3 decrement again");
        tk();
        chk(A_REM, 0, 1, 1, "R4 reach zero");
        chk(A_STAT, 1, 1, 1, "R4 pending set");
        tk();
        chk(A_REM, 0, 1, 1, "R4 parked at zero");

        // R5: write-zero ignored, enable clear keeps pending, W1C
        wr(A_STAT, 0);
        chk(A_STAT, 1, 1, 1, "R5 write zero ignored");
        wr(A_RUN, 0);
        chk(A_STAT, 1, 1, 1, "R5 pending kept after disable");
        wr(A_STAT, 1);
        chk(A_STAT, 0, 0, 0, "R5 cleared");
        tk();
        chk(A_STAT, 0, 0, 0, "R4 no second set");

        // R6 / R7: output gating
        wr(A_IE, 0);
        wr(A_LOAD, 1);
        tk();
        wr(A_RUN, 1);
        tk();
        chk(A_STAT, 1, 0, 1, "R6 irq gated off, R7 wake on");
        wr(A_WAKE, 0);
        chk(A_STAT, 1, 0, 0, "R7 wake gated off");
        wr(A_IE, 1);
        chk(A_STAT, 1, 1, 0, "R6 irq on");
        wr(A_STAT, 1);
        chk(A_STAT, 0, 0, 0, "R6 irq drops on clear");

        // R8: cancel with a zero load
        wr(A_LOAD, 5);
        tk();
        tk();
        chk(A_REM, 4, 0, 0, "R8 counting");
        wr(A_LOAD, 0);
        chk(A_REM, 0, 0, 0, "R8 cancelled");
        for (int i = 0; i < 6; i++) tk();
        chk(A_STAT, 0, 0, 0, "R8 no pending after cancel");
        chk(A_REM, 0, 0, 0, "R8 remain stays zero");

        // R9: expiry and clear on the same edge
        wr(A_LOAD, 2);
        tk();
        tk();
        chk(A_REM, 1, 0, 0, "R9 one left");
        drive(1'b1, A_STAT, 32'd1, 1'b1);
        chk(A_STAT, 1, 1, 0, "R9 set wins over clear");
        wr(A_STAT, 1);

        // R10: load write and tick on the same edge
        wr(A_LOAD, 5);
        tk();
        tk();
        chk(A_REM, 4, 0, 0, "R10 counting");
        drive(1'b1, A_LOAD, 32'd2, 1'b1);
        chk(A_REM, 4, 0, 0, "R10 tick not used");
        chk(A_LOAD, 2, 0, 0, "R10 staged value");
        tk();
        chk(A_REM, 2, 0, 0, "R10 adopted next tick");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule